// File: doc/BRIEF.md
# Glitch-Free Clock Output Gate Controller

This block sits behind the clock synthesizer of a system clock generator. It takes the source clocks for the processor group, the memory group and the peripheral-bus group, and produces from each one free-running copy and a set of gated copies: three processor outputs, twelve memory outputs and five peripheral-bus outputs. Each gated copy runs only when its enable bit from the control register is set and the stop pin that governs its group is released. The processor stop pin governs both the processor and the memory outputs; the bus stop pin governs the bus outputs.

Both stop pins are active low and asynchronous. A mode strap is captured while reset is held. In mobile mode (strap 0) the stop pins act. In desktop mode (strap 1) the stop pins are ignored and the shared pad carries the reference clock out instead. The stop pins and the enable bits are brought into the free-running bus clock domain by two-flop synchronizers. A gate changes state only after a rising edge of the free-running bus clock followed by a falling edge of the clock it gates. A stopped output therefore parks low, and its last high pulse keeps its full width.

All source clocks are assumed to come from one PLL and to have a fixed phase relation. The processor clock leads the bus clock. There is no data path and so no valid/ready interface: every pin is a clock or a plain level.

Top module: `clk_out_gate`

## Requirements
- R1: A gated output that is stopped sits at logic 0, never at logic 1.
- R2: A gate opens or closes only on a falling edge of its own source clock, after the request has been registered on a rising edge of the free-running bus clock. Every high pulse on a gated output lasts a full source high phase: 5 ns for the processor and memory clocks and 15 ns for the bus clock in the bench.
- R3: In mobile mode, driving `cpu_stop_n_i` low stops all `cpu_clk_o` and all `sdram_clk_o` bits.
- R4: In mobile mode, driving `pci_stop_n_i` low stops all `pci_clk_o` bits. It has no effect on the processor or memory outputs.
- R5: `cpu_free_o`, `sdram_free_o` and `pci_free_o` always follow their source clocks, whatever the stop pins and enable bits are.
- R6: Gated output bit i runs only when enable bit i is 1 and its group's stop is not in force. It is the logical AND of the two.
- R7: `mode_strap_i` is captured on rising bus-clock edges while `rst_n_i` is low. Changes to the strap after reset release have no effect until the next reset.
- R8: With a captured mode of 1, both stop pins are ignored and `ref_clk_o` follows `clk_ref_i`. With a captured mode of 0, `ref_clk_o` is held at 0.
- R9: After reset, with all enable bits at 1 and both stop pins high, every gated output runs. The gates come out of reset open.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_pci_i | input | 1 | Bus source clock; also clocks the synchronizers and the request register |
| clk_cpu_i | input | 1 | Processor source clock |
| clk_sdram_i | input | 1 | Memory source clock (buffer input) |
| clk_ref_i | input | 1 | Reference clock for the shared pad |
| rst_n_i | input | 1 | Active-low reset, asynchronous assert |
| mode_strap_i | input | 1 | Mode strap: 0 mobile (stops active), 1 desktop (reference out) |
| cpu_stop_n_i | input | 1 | Active-low asynchronous stop for processor and memory outputs |
| pci_stop_n_i | input | 1 | Active-low asynchronous stop for bus outputs |
| cpu_en_i | input | N_CPU | Register enables, one per gated processor output |
| sdram_en_i | input | N_SDRAM | Register enables, one per gated memory output |
| pci_en_i | input | N_PCI | Register enables, one per gated bus output |
| cpu_free_o | output | 1 | Free-running processor clock |
| cpu_clk_o | output | N_CPU | Gated processor clocks |
| sdram_free_o | output | 1 | Free-running memory clock |
| sdram_clk_o | output | N_SDRAM | Gated memory clocks |
| pci_free_o | output | 1 | Free-running bus clock |
| pci_clk_o | output | N_PCI | Gated bus clocks |
| ref_clk_o | output | 1 | Reference clock out in desktop mode, 0 in mobile mode |

## Verification
Two things can land in the same bus-clock cycle: a stop pin changing and a register enable changing for the same outputs. The bench provokes this by releasing the processor stop and clearing enable bits of both the processor and memory groups in one step. It then judges the result in two ways. The per-output activity mask must show only the still-enabled outputs resuming. A pulse-width monitor must see no shortened high pulse on the gated outputs while the two requests are resolved at the falling edges that follow.

// File: rtl/clk_gate_pkg.sv
`timescale 1ns/1ps
package clk_gate_pkg;

  typedef enum logic {
    MODE_MOBILE  = 1'b0,
    MODE_DESKTOP = 1'b1
  } strap_mode_e;

  localparam int unsigned DEF_N_CPU   = 3;
  localparam int unsigned DEF_N_SDRAM = 12;
  localparam int unsigned DEF_N_PCI   = 5;
  localparam int unsigned DEF_SYNC    = 2;

endpackage

// File: rtl/cg_sync.sv
`timescale 1ns/1ps
module cg_sync #(
  parameter int unsigned W      = 1,
  parameter int unsigned STAGES = 2,
  parameter logic        RST_VAL = 1'b1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  logic [W-1:0] stg [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < STAGES; i++) stg[i] <= {W{RST_VAL}};
    end else begin
      stg[0] <= d;
      for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
    end
  end

  assign q = stg[STAGES-1];

endmodule

// File: rtl/cg_req.sv
`timescale 1ns/1ps
module cg_req #(
  parameter int unsigned N_CPU   = 3,
  parameter int unsigned N_SDRAM = 12,
  parameter int unsigned N_PCI   = 5
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               stops_live,
  input  logic               cpu_stop,
  input  logic               pci_stop,
  input  logic [N_CPU-1:0]   cpu_en,
  input  logic [N_SDRAM-1:0] sdram_en,
  input  logic [N_PCI-1:0]   pci_en,
  output logic [N_CPU-1:0]   cpu_req,
  output logic [N_SDRAM-1:0] sdram_req,
  output logic [N_PCI-1:0]   pci_req
);

  logic cpu_hold, pci_hold;

  always_comb begin
    cpu_hold = stops_live & cpu_stop;
    pci_hold = stops_live & pci_stop;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cpu_req   <= '1;
      sdram_req <= '1;
      pci_req   <= '1;
    end else begin
      cpu_req   <= cpu_en   & {N_CPU{~cpu_hold}};
      sdram_req <= sdram_en & {N_SDRAM{~cpu_hold}};
      pci_req   <= pci_en   & {N_PCI{~pci_hold}};
    end
  end

  // R3
  cpu_stop_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(cpu_stop) && $past(stops_live)) |-> (cpu_req == '0 && sdram_req == '0));

  // R4
  pci_stop_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(pci_stop) && $past(stops_live)) |-> (pci_req == '0));

  // R6
  en_gates_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((cpu_req & ~$past(cpu_en)) == '0) && ((pci_req & ~$past(pci_en)) == '0)
    && ((sdram_req & ~$past(sdram_en)) == '0));

endmodule

// File: rtl/cg_gate.sv
`timescale 1ns/1ps
module cg_gate #(
  parameter int unsigned N = 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] req,
  output logic [N-1:0] gclk
);

  logic [N-1:0] open_q;

  for (genvar g = 0; g < N; g++) begin : g_bit
    always_ff @(negedge clk or negedge rst_n) begin
      if (!rst_n) open_q[g] <= 1'b1;
      else        open_q[g] <= req[g];
    end
    assign gclk[g] = clk & open_q[g];
  end

  always @(open_q) begin
    if (rst_n) begin
      // R2
      open_change_low_chk: assert (clk == 1'b0)
        else $error("gate state changed while source clock high");
    end
  end

endmodule

// File: rtl/clk_out_gate.sv
`timescale 1ns/1ps
module clk_out_gate
  import clk_gate_pkg::*;
#(
  parameter int unsigned N_CPU   = DEF_N_CPU,
  parameter int unsigned N_SDRAM = DEF_N_SDRAM,
  parameter int unsigned N_PCI   = DEF_N_PCI,
  parameter int unsigned SYNC    = DEF_SYNC
) (
  input  logic               clk_pci_i,
  input  logic               clk_cpu_i,
  input  logic               clk_sdram_i,
  input  logic               clk_ref_i,
  input  logic               rst_n_i,
  input  logic               mode_strap_i,
  input  logic               cpu_stop_n_i,
  input  logic               pci_stop_n_i,
  input  logic [N_CPU-1:0]   cpu_en_i,
  input  logic [N_SDRAM-1:0] sdram_en_i,
  input  logic [N_PCI-1:0]   pci_en_i,
  output logic               cpu_free_o,
  output logic [N_CPU-1:0]   cpu_clk_o,
  output logic               sdram_free_o,
  output logic [N_SDRAM-1:0] sdram_clk_o,
  output logic               pci_free_o,
  output logic [N_PCI-1:0]   pci_clk_o,
  output logic               ref_clk_o
);

  localparam int unsigned N_EN = N_CPU + N_SDRAM + N_PCI;

  strap_mode_e mode_q;
  logic [1:0]  stop_n_s;
  logic [N_EN-1:0] en_s;
  logic [N_CPU-1:0]   cpu_req;
  logic [N_SDRAM-1:0] sdram_req;
  logic [N_PCI-1:0]   pci_req;

  always_ff @(posedge clk_pci_i) begin
    if (!rst_n_i) mode_q <= strap_mode_e'(mode_strap_i);
  end

  // R7
  mode_frozen_chk: assert property (@(posedge clk_pci_i) disable iff (!rst_n_i)
    rst_n_i |=> $stable(mode_q));

  cg_sync #(.W(2), .STAGES(SYNC), .RST_VAL(1'b1)) u_stop_sync (
    .clk   (clk_pci_i),
    .rst_n (rst_n_i),
    .d     ({pci_stop_n_i, cpu_stop_n_i}),
    .q     (stop_n_s)
  );

  cg_sync #(.W(N_EN), .STAGES(SYNC), .RST_VAL(1'b1)) u_en_sync (
    .clk   (clk_pci_i),
    .rst_n (rst_n_i),
    .d     ({pci_en_i, sdram_en_i, cpu_en_i}),
    .q     (en_s)
  );

  cg_req #(.N_CPU(N_CPU), .N_SDRAM(N_SDRAM), .N_PCI(N_PCI)) u_req (
    .clk        (clk_pci_i),
    .rst_n      (rst_n_i),
    .stops_live (mode_q == MODE_MOBILE),
    .cpu_stop   (~stop_n_s[0]),
    .pci_stop   (~stop_n_s[1]),
    .cpu_en     (en_s[N_CPU-1:0]),
    .sdram_en   (en_s[N_CPU+N_SDRAM-1:N_CPU]),
    .pci_en     (en_s[N_EN-1:N_CPU+N_SDRAM]),
    .cpu_req    (cpu_req),
    .sdram_req  (sdram_req),
    .pci_req    (pci_req)
  );

  cg_gate #(.N(N_CPU)) u_gate_cpu (
    .clk (clk_cpu_i), .rst_n (rst_n_i), .req (cpu_req), .gclk (cpu_clk_o)
  );

  cg_gate #(.N(N_SDRAM)) u_gate_sdram (
    .clk (clk_sdram_i), .rst_n (rst_n_i), .req (sdram_req), .gclk (sdram_clk_o)
  );

  cg_gate #(.N(N_PCI)) u_gate_pci (
    .clk (clk_pci_i), .rst_n (rst_n_i), .req (pci_req), .gclk (pci_clk_o)
  );

  assign cpu_free_o   = clk_cpu_i;
  assign sdram_free_o = clk_sdram_i;
  assign pci_free_o   = clk_pci_i;
  assign ref_clk_o    = clk_ref_i & (mode_q == MODE_DESKTOP);

endmodule

// File: tb/clk_out_gate_tb_top.sv
`timescale 1ns/1ps
module clk_out_gate_tb_top;

  localparam real CLK_PERIOD = 10.0;
  localparam int NC = 3, NS = 12, NP = 5;
  localparam int NM = NC + NS + NP + 4;

  typedef struct {
    logic [NM-1:0] mask;
    string         tag;
  } sb_item_t;

  logic clk_pci = 0, clk_cpu = 0, clk_sdram = 0, clk_ref = 0;
  logic rst_n = 0, mode_strap = 0, cpu_stop_n = 1, pci_stop_n = 1;
  logic [NC-1:0] cpu_en = '1;
  logic [NS-1:0] sdram_en = '1;
  logic [NP-1:0] pci_en = '1;
  logic cpu_free, sdram_free, pci_free, ref_clk;
  logic [NC-1:0] cpu_clk;
  logic [NS-1:0] sdram_clk;
  logic [NP-1:0] pci_clk;

  int checks = 0, fails = 0;
  int n_q = 0;
  bit mon_on = 0;
  logic mode_lat = 0;
  sb_item_t q[$];

  initial forever #(CLK_PERIOD/2) clk_cpu = ~clk_cpu;
  initial begin #1; forever #(CLK_PERIOD/2) clk_sdram = ~clk_sdram; end
  initial begin #2; forever #(CLK_PERIOD*1.5) clk_pci = ~clk_pci; end
  initial begin #3; forever #7 clk_ref = ~clk_ref; end

  clk_out_gate dut_i (
    .clk_pci_i(clk_pci), .clk_cpu_i(clk_cpu), .clk_sdram_i(clk_sdram),
    .clk_ref_i(clk_ref), .rst_n_i(rst_n), .mode_strap_i(mode_strap),
    .cpu_stop_n_i(cpu_stop_n), .pci_stop_n_i(pci_stop_n),
    .cpu_en_i(cpu_en), .sdram_en_i(sdram_en), .pci_en_i(pci_en),
    .cpu_free_o(cpu_free), .cpu_clk_o(cpu_clk), .sdram_free_o(sdram_free),
    .sdram_clk_o(sdram_clk), .pci_free_o(pci_free), .pci_clk_o(pci_clk),
    .ref_clk_o(ref_clk)
  );

  // Observed vector: {ref, pci_free, pci[4:0], sdram_free, sdram[11:0], cpu_free, cpu[2:0]}
  function automatic logic [NM-1:0] expected();
    logic run_c, run_p;
    run_c = mode_lat | cpu_stop_n;
    run_p = mode_lat | pci_stop_n;
    return {mode_lat, 1'b1, pci_en & {NP{run_p}}, 1'b1,
            sdram_en & {NS{run_c}}, 1'b1, cpu_en & {NC{run_c}}};
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input logic [NM-1:0] act, input logic [NM-1:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic push_expect(input string tag);
    sb_item_t it;
    repeat (6) @(posedge clk_pci);
    it.mask = expected();
    it.tag  = tag;
    q.push_back(it);
    n_q++;
    wait (n_q == 0);
  endtask

  task automatic do_reset(input logic m);
    mon_on = 0;
    mode_strap = m;
    rst_n = 0;
    repeat (4) @(posedge clk_pci);
    #4 rst_n = 1;
    mode_lat = m;
    repeat (4) @(posedge clk_pci);
    mon_on = 1;
  endtask

  // Scoreboard monitor: activity over a window must match the expected mask
  initial begin
    forever begin
      logic [NM-1:0] seen;
      sb_item_t it;
      wait (n_q > 0);
      it = q[0];
      seen = '0;
      repeat (150) begin
        #1;
        seen |= {ref_clk, pci_free, pci_clk, sdram_free, sdram_clk, cpu_free, cpu_clk};
      end
      check(seen == it.mask, it.tag, "activity mask", seen, it.mask);
      void'(q.pop_front());
      n_q--;
    end
  end

  // R2: full-width high pulses on gated outputs
  realtime tc = 0, ts = 0, tp = 0;
  always @(posedge cpu_clk[1]) tc = $realtime;
  always @(negedge cpu_clk[1])
    if (mon_on) check(($realtime - tc) > 4.99 && ($realtime - tc) < 5.01,
                      "R2", "cpu pulse width", NM'(int'($realtime - tc)), NM'(5));
  always @(posedge sdram_clk[5]) ts = $realtime;
  always @(negedge sdram_clk[5])
    if (mon_on) check(($realtime - ts) > 4.99 && ($realtime - ts) < 5.01,
                      "R2", "sdram pulse width", NM'(int'($realtime - ts)), NM'(5));
  always @(posedge pci_clk[3]) tp = $realtime;
  always @(negedge pci_clk[3])
    if (mon_on) check(($realtime - tp) > 14.99 && ($realtime - tp) < 15.01,
                      "R2", "pci pulse width", NM'(int'($realtime - tp)), NM'(15));

  initial begin
    repeat (100000) @(posedge clk_cpu);
    checks++; fails++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    do_reset(1'b0);
    push_expect("R9 R8 reset state mobile");

    cpu_stop_n = 0;
    push_expect("R3 R1 R5 cpu stop");

    pci_stop_n = 0;
    push_expect("R4 R1 R5 both stops");

    // concurrent: stop release and enable clears in the same step
    cpu_stop_n = 0; #0;
    cpu_stop_n = 1; cpu_en[1] = 0; sdram_en[5] = 0;
    push_expect("R6 R2 stop release with enable clear");

    pci_stop_n = 1; pci_en[3] = 0;
    push_expect("R6 R4 pci enable clear");

    cpu_en = '1; sdram_en = '1; pci_en = '1;
    push_expect("R6 R2 enables restored");

    pci_stop_n = 0; pci_en[0] = 0;
    push_expect("R4 R6 stop with enable clear");

    mode_strap = 1; pci_stop_n = 1; pci_en = '1; cpu_stop_n = 0;
    push_expect("R7 strap change after reset ignored");

    cpu_stop_n = 0; pci_stop_n = 0;
    do_reset(1'b1);
    push_expect("R8 R5 stops ignored in desktop mode");

    cpu_en[0] = 0; sdram_en[11] = 0; pci_en[4] = 0;
    push_expect("R8 R6 enables still act in desktop mode");

    cpu_en = '1; sdram_en = '1; pci_en = '1;
    do_reset(1'b0);
    push_expect("R7 R3 R4 strap recaptured at reset");

    cpu_stop_n = 1; pci_stop_n = 1;
    push_expect("R9 R1 all running again");

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule